// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the already-synchronized input levels of a 32-pin GPIO bank and turns selected pin conditions into interrupts. Each pin can be armed for any mix of four detection kinds: level low, level high, rising edge and falling edge. Each kind has its own read/write mask register. Every qualifying condition sets a bit in one raw status vector that both interrupt lines share.

Two independent enable vectors, one per interrupt line, gate the raw status onto two registered interrupt outputs. Software sets enable bits by writing ones to a set offset and clears them by writing ones to a clear offset. It acknowledges status bits by writing ones to either masked-status offset. A zero bit in any of these write-one ports leaves the state alone.

The register bus is a single-cycle write strobe with address and data. Read data is a combinational function of the address. A package function decodes each address into a register selector. This selector is the only decision point; no sequencing state exists. Every access completes in the cycle it is presented.

Top module: `gpio_pin_irq_unit`

## Requirements
- R1: After reset all detection masks, both enable vectors and the raw status are zero, both interrupt outputs are low, and reads of every register return zero.
- R2: A pin armed for low level (mask at 0x140) sets its status bit while the pin is 0. Writing a one to clear that bit while the pin is still 0 leaves it set.
- R3: A pin armed for high level (mask at 0x144) sets its status bit one cycle after the pin is seen at 1.
- R4: A pin armed for rising edge (mask at 0x148) sets its status bit when the current sample is 1 and the previous sample was 0. The bit stays set after the pin returns to 0, until it is cleared.
- R5: A pin armed for falling edge (mask at 0x14C) sets its status bit on a 1-to-0 change and not on a 0-to-1 change.
- R6: A pin armed for both rising and falling edge sets its status on each change of level.
- R7: Writing ones to 0x02C or 0x030 clears those raw status bits. Zero bits in the written word leave status unchanged.
- R8: When a detected condition and a status clear reach the same bit in the same cycle, the bit ends up set.
- R9: Writing ones to 0x034/0x038 sets line 0/line 1 enable bits, and writing ones to 0x03C/0x040 clears them. Zero bits have no effect. Both the set and the clear offset of a line read back that line's enable vector.
- R10: Each interrupt output is high exactly one cycle after the OR of raw status AND its line's enables is nonzero. Offset 0x02C reads raw AND line-0 enables and 0x030 reads raw AND line-1 enables, so each line is masked independently.
- R11: The four detection masks at 0x140, 0x144, 0x148 and 0x14C are plain read/write registers.
- R12: Raw status reads the same at 0x024 and 0x028 whatever the enables are. Writes to these two offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_line0 | output | 1 | Interrupt line 0, registered |
| irq_line1 | output | 1 | Interrupt line 1, registered |

## Verification
Each detection kind is driven on its own pin with a level pattern that separates it from the others. A high-then-low pulse shows that edge bits stay latched after the pin returns. A pin held low under a clear shows that a live level re-asserts its bit. The falling-only pin is first raised, and status must stay clear, then dropped. This tells falling detection apart from any-change detection, while the pin armed for both edges must react to both. A clear write that lands in the very cycle of a rising edge shows the priority of set over clear. Enables are split across the two lines so that a status bit seen on one line and absent on the other exposes mixed-up masks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W  = 12;
    localparam int N_LINES = 2;

    localparam logic [ADDR_W-1:0] OFS_RAW_A   = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_RAW_B   = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_MSK_A   = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_MSK_B   = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_SETEN_A = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_SETEN_B = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_CLREN_A = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_CLREN_B = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_LOW     = 12'h140;
    localparam logic [ADDR_W-1:0] OFS_HIGH    = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_RISE    = 12'h148;
    localparam logic [ADDR_W-1:0] OFS_FALL    = 12'h14C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RAW_A,
        SEL_RAW_B,
        SEL_MSK_A,
        SEL_MSK_B,
        SEL_SETEN_A,
        SEL_SETEN_B,
        SEL_CLREN_A,
        SEL_CLREN_B,
        SEL_LOW,
        SEL_HIGH,
        SEL_RISE,
        SEL_FALL
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_RAW_A:   s = SEL_RAW_A;
            OFS_RAW_B:   s = SEL_RAW_B;
            OFS_MSK_A:   s = SEL_MSK_A;
            OFS_MSK_B:   s = SEL_MSK_B;
            OFS_SETEN_A: s = SEL_SETEN_A;
            OFS_SETEN_B: s = SEL_SETEN_B;
            OFS_CLREN_A: s = SEL_CLREN_A;
            OFS_CLREN_B: s = SEL_CLREN_B;
            OFS_LOW:     s = SEL_LOW;
            OFS_HIGH:    s = SEL_HIGH;
            OFS_RISE:    s = SEL_RISE;
            OFS_FALL:    s = SEL_FALL;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output reg_sel_e          sel,
    output logic [NPINS-1:0]  det_low,
    output logic [NPINS-1:0]  det_high,
    output logic [NPINS-1:0]  det_rise,
    output logic [NPINS-1:0]  det_fall,
    output logic [NPINS-1:0]  en_a,
    output logic [NPINS-1:0]  en_b,
    output logic [NPINS-1:0]  st_clr
);

    assign sel = decode_ofs(bus_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_low  <= '0;
            det_high <= '0;
            det_rise <= '0;
            det_fall <= '0;
            en_a     <= '0;
            en_b     <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_LOW:     det_low  <= bus_wdata;
                SEL_HIGH:    det_high <= bus_wdata;
                SEL_RISE:    det_rise <= bus_wdata;
                SEL_FALL:    det_fall <= bus_wdata;
                SEL_SETEN_A: en_a     <= en_a | bus_wdata;
                SEL_SETEN_B: en_b     <= en_b | bus_wdata;
                SEL_CLREN_A: en_a     <= en_a & ~bus_wdata;
                SEL_CLREN_B: en_b     <= en_b & ~bus_wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        st_clr = '0;
        if (bus_wr && (sel == SEL_MSK_A || sel == SEL_MSK_B))
            st_clr = bus_wdata;
    end

    // R9: ones written to a set port appear in the enable vector next cycle
    assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_SETEN_A) |=> ((en_a & $past(bus_wdata)) == $past(bus_wdata)));

    // R9: ones written to a clear port vanish from the enable vector
    assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CLREN_B) |=> ((en_b & $past(bus_wdata)) == '0));

    // R9: an all-zero write to a set or clear port changes nothing
    assert_en_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == '0 && (sel == SEL_SETEN_A || sel == SEL_CLREN_A))
        |=> $stable(en_a));

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] det_low,
    input  logic [NPINS-1:0] det_high,
    input  logic [NPINS-1:0] det_rise,
    input  logic [NPINS-1:0] det_fall,
    output logic [NPINS-1:0] ev
);

    logic [NPINS-1:0] prev_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= pin_lvl;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic is_lo, is_hi, went_up, went_dn;
        always_comb begin
            is_lo   = det_low[p]  & ~pin_lvl[p];
            is_hi   = det_high[p] &  pin_lvl[p];
            went_up = det_rise[p] &  pin_lvl[p] & ~prev_lvl[p];
            went_dn = det_fall[p] & ~pin_lvl[p] &  prev_lvl[p];
            ev[p]   = is_lo | is_hi | went_up | went_dn;
        end
    end

    // R4: with no kind armed on any pin no condition is reported
    assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((det_low | det_high | det_rise | det_fall) == '0) |-> (ev == '0));

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ev,
    input  logic [NPINS-1:0] st_clr,
    input  logic [NPINS-1:0] en_a,
    input  logic [NPINS-1:0] en_b,
    output logic [NPINS-1:0] raw,
    output logic [N_LINES-1:0] irq
);

    logic [NPINS-1:0] line_en [N_LINES];

    assign line_en[0] = en_a;
    assign line_en[1] = en_b;

    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~st_clr) | ev;
    end

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) irq[k] <= 1'b0;
            else        irq[k] <= |(raw & line_en[k]);
        end

        // R10: each line follows its masked status one cycle later
        assert_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq[k] == $past(|(raw & line_en[k]))));
    end

    // R8: any detected condition is latched, even against a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(ev)) == $past(ev)));

    // R7: cleared bits without a fresh condition read zero next cycle
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(st_clr & ~ev)) == '0));

    // R4: a set bit with no clear stays set
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(raw & ~st_clr)) == $past(raw & ~st_clr)));

endmodule

// File: rtl/gpio_pin_irq_unit.sv
module gpio_pin_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq_line0,
    output logic              irq_line1
);

    reg_sel_e         sel;
    logic [NPINS-1:0] det_low, det_high, det_rise, det_fall;
    logic [NPINS-1:0] en_a, en_b, st_clr, ev, raw;
    logic [N_LINES-1:0] irq;

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .sel(sel), .det_low(det_low),
        .det_high(det_high), .det_rise(det_rise), .det_fall(det_fall),
        .en_a(en_a), .en_b(en_b), .st_clr(st_clr)
    );

    gpio_edge_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .det_low(det_low),
        .det_high(det_high), .det_rise(det_rise), .det_fall(det_fall),
        .ev(ev)
    );

    gpio_irq_status #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev(ev), .st_clr(st_clr),
        .en_a(en_a), .en_b(en_b), .raw(raw), .irq(irq)
    );

    assign irq_line0 = irq[0];
    assign irq_line1 = irq[1];

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_RAW_A, SEL_RAW_B:     bus_rdata = raw;
            SEL_MSK_A:                bus_rdata = raw & en_a;
            SEL_MSK_B:                bus_rdata = raw & en_b;
            SEL_SETEN_A, SEL_CLREN_A: bus_rdata = en_a;
            SEL_SETEN_B, SEL_CLREN_B: bus_rdata = en_b;
            SEL_LOW:                  bus_rdata = det_low;
            SEL_HIGH:                 bus_rdata = det_high;
            SEL_RISE:                 bus_rdata = det_rise;
            SEL_FALL:                 bus_rdata = det_fall;
            default:                  bus_rdata = '0;
        endcase
    end

    // R12: writes aimed at the raw offsets never clear status
    assert_raw_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_RAW_A || sel == SEL_RAW_B)) |=> ((raw & $past(raw)) == $past(raw)));

endmodule

// File: tb/sim_gpio_pin_irq_unit.sv
module sim_gpio_pin_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_line0, irq_line1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_pin_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line0(irq_line0), .irq_line1(irq_line1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pin(input int b, input logic v);
        @(negedge clk);
        pin_lvl[b] = v;
        @(negedge clk);
    endtask

    task automatic quiet();
        wr(12'h140, '0); wr(12'h144, '0); wr(12'h148, '0); wr(12'h14C, '0);
        @(negedge clk); pin_lvl = '0; @(negedge clk);
        wr(12'h02C, '1); wr(12'h03C, '1); wr(12'h040, '1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        foreach (v[i]) ;
        rd(12'h024, v); chk("R1 raw", v, 0);
        rd(12'h034, v); chk("R1 en0", v, 0);
        rd(12'h040, v); chk("R1 en1", v, 0);
        rd(12'h148, v); chk("R1 rise mask", v, 0);
        chk("R1 irq0", {31'd0, irq_line0}, 0);
        chk("R1 irq1", {31'd0, irq_line1}, 0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(12'h140, 32'hA5A5_0001); wr(12'h144, 32'h0F0F_0002);
        wr(12'h148, 32'h1234_0004); wr(12'h14C, 32'hCAFE_0008);
        rd(12'h140, v); chk("R11 low", v, 32'hA5A5_0001);
        rd(12'h144, v); chk("R11 high", v, 32'h0F0F_0002);
        rd(12'h148, v); chk("R11 rise", v, 32'h1234_0004);
        rd(12'h14C, v); chk("R11 fall", v, 32'hCAFE_0008);
        quiet();
    endtask

    task automatic t_enables();
        logic [31:0] v;
        wr(12'h034, 32'h0000_00F0);
        rd(12'h034, v); chk("R9 set0 read", v, 32'hF0);
        rd(12'h03C, v); chk("R9 clr0 read", v, 32'hF0);
        wr(12'h034, 32'h0);
        rd(12'h034, v); chk("R9 zero set", v, 32'hF0);
        wr(12'h03C, 32'h30);
        rd(12'h03C, v); chk("R9 clr0", v, 32'hC0);
        wr(12'h038, 32'h3);
        rd(12'h038, v); chk("R9 set1", v, 32'h3);
        rd(12'h034, v); chk("R9 line0 untouched", v, 32'hC0);
        wr(12'h040, 32'h0);
        rd(12'h040, v); chk("R9 zero clr", v, 32'h3);
        quiet();
    endtask

    task automatic t_high();
        logic [31:0] v;
        wr(12'h144, 32'h10); wr(12'h034, 32'h10);
        rd(12'h024, v); chk("R3 idle", v, 0);
        @(negedge clk); pin_lvl[4] = 1'b1;
        @(negedge clk);
        rd(12'h024, v); chk("R3 set", v, 32'h10);
        chk("R10 irq0 not yet", {31'd0, irq_line0}, 0);
        @(negedge clk);
        chk("R10 irq0", {31'd0, irq_line0}, 1);
        chk("R10 irq1 masked", {31'd0, irq_line1}, 0);
        rd(12'h02C, v); chk("R10 msk0", v, 32'h10);
        rd(12'h030, v); chk("R10 msk1", v, 0);
        pin(4, 1'b0);
        wr(12'h02C, 32'h10);
        rd(12'h024, v); chk("R7 cleared", v, 0);
        @(negedge clk);
        chk("R10 irq0 drop", {31'd0, irq_line0}, 0);
        quiet();
    endtask

    task automatic t_low();
        logic [31:0] v;
        wr(12'h140, 32'h4);
        @(negedge clk);
        rd(12'h024, v); chk("R2 set", v, 32'h4);
        wr(12'h02C, 32'h4);
        rd(12'h024, v); chk("R2 reassert", v, 32'h4);
        pin(2, 1'b1);
        wr(12'h030, 32'h4);
        rd(12'h024, v); chk("R7 clear via line1 port", v, 0);
        quiet();
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(12'h148, 32'h200); wr(12'h038, 32'h200);
        pin(9, 1'b1);
        rd(12'h024, v); chk("R4 set", v, 32'h200);
        pin(9, 1'b0);
        rd(12'h024, v); chk("R4 held", v, 32'h200);
        chk("R10 irq1", {31'd0, irq_line1}, 1);
        chk("R10 irq0 other line", {31'd0, irq_line0}, 0);
        rd(12'h030, v); chk("R10 msk1", v, 32'h200);
        rd(12'h02C, v); chk("R10 msk0 empty", v, 0);
        wr(12'h02C, 32'h0);
        rd(12'h024, v); chk("R7 zero write", v, 32'h200);
        wr(12'h024, 32'hFFFF_FFFF); wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h028, v); chk("R12 raw ro", v, 32'h200);
        rd(12'h024, v); chk("R12 raw alias", v, 32'h200);
        wr(12'h02C, 32'h200);
        @(negedge clk);
        rd(12'h024, v); chk("R4 stays clear", v, 0);
        quiet();
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(12'h14C, 32'h400);
        pin(10, 1'b1);
        rd(12'h024, v); chk("R5 no rise", v, 0);
        pin(10, 1'b0);
        rd(12'h024, v); chk("R5 fall", v, 32'h400);
        quiet();
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(12'h148, 32'h1000); wr(12'h14C, 32'h1000);
        pin(12, 1'b1);
        rd(12'h024, v); chk("R6 up", v, 32'h1000);
        wr(12'h02C, 32'h1000);
        rd(12'h024, v); chk("R6 cleared", v, 0);
        pin(12, 1'b0);
        rd(12'h024, v); chk("R6 down", v, 32'h1000);
        quiet();
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(12'h148, 32'h80);
        rd(12'h024, v); chk("R8 before", v, 0);
        @(negedge clk);
        pin_lvl[7] = 1'b1;
        bus_wr = 1'b1; bus_addr = 12'h02C; bus_wdata = 32'h80;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(12'h024, v); chk("R8 set wins", v, 32'h80);
        quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_enables();
        t_high();
        t_low();
        t_rise();
        t_fall();
        t_both();
        t_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule